// File: doc/BRIEF.md
# Flash Block Protection Checker

This block sits between a flash command interface and its write state machine. It decides whether a program or erase may go ahead. Each request carries a 20-bit word address and an operation code. The address is mapped onto an uneven block layout. The bottom of the array holds eight small 16K-word blocks: the boot block at index 0 and seven parameter blocks after it. These eight form bank 0. Above them sit twenty-eight 32K-word main blocks, indices 8 to 35, which form bank 1.

One lock bit is kept for each block, where 1 means unlocked and 0 means locked. Three things decide the answer:

- an active-low guard pin, which overrides every lock bit while it is high;
- the lock bit of the addressed block;
- a supply-lockout input, which makes the whole array read-only.

One clock after each request the block returns a grant or a block-fail flag, together with the block index and the bank. A granted erase unlocks its block. A granted lock operation locks it. A refused request changes no lock bit.

Top module: `flash_protect_check`

## Requirements
- R1: An address below 0x20000 maps to block addr/16384 (0..7) in bank 0 (rsp_bank = 0).
- R2: An address at or above 0x20000 maps to block 8 + (addr - 0x20000)/32768 (8..35) in bank 1 (rsp_bank = 1).
- R3: A request sampled on a clock edge with req_valid high produces rsp_valid high after exactly that edge. No request means rsp_valid is low after the edge. A request sees the lock bits as left by the request in the previous cycle.
- R4: With write_guard_n = 0 and supply_low = 0, a program (op 2'b00) or erase (op 2'b01) to a block whose lock bit is 0 is refused: rsp_grant = 0 and rsp_fail = 1.
- R5: With write_guard_n = 1 and supply_low = 0, a program or erase is granted whatever the lock bit is. A program leaves the lock bit as it was.
- R6: A granted erase sets the addressed block's lock bit to 1, so later programs to it are granted with write_guard_n = 0.
- R7: While supply_low = 1, every request is refused (rsp_grant = 0, rsp_fail = 1).
- R8: A refused request leaves every lock bit unchanged.
- R9: After reset rsp_valid and rsp_grant are 0 and every lock bit is 1.
- R10: A lock operation (op 2'b10) with supply_low = 0 is granted whatever write_guard_n is, and clears the block's lock bit to 0. Op 2'b11 is always refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 00 program, 01 erase, 10 lock, 11 reserved |
| req_addr | input | 20 | Word address of the request |
| write_guard_n | input | 1 | Guard pin; high overrides the lock bits |
| supply_low | input | 1 | Supply below the lockout threshold |
| rsp_valid | output | 1 | Result present |
| rsp_grant | output | 1 | Request permitted |
| rsp_fail | output | 1 | Block-fail flag; request refused |
| rsp_block | output | 6 | Block index 0..35 |
| rsp_bank | output | 1 | 0 for the small-block bank, 1 for the main bank |

## Verification
Every result, including grant, fail, block index and bank, is due one clock after the edge that samples its request. The lock bit written by a granted erase or lock operation takes effect for a request in the very next cycle. The bench drives requests on the falling edge and pushes the expected result into a queue at that moment. A monitor samples 1 ns after the following rising edge. It reports a missing result as late, and an extra result as unexpected. Lock effects are observed through the grant or refusal of later requests, including a program issued back-to-back after a lock.

// File: rtl/flash_prot_pkg.sv
package flash_prot_pkg;
  localparam int ADDR_W    = 20;
  localparam int SMALL_CNT = 8;
  localparam int SMALL_LOG = 14;
  localparam int BIG_CNT   = 28;
  localparam int BIG_LOG   = 15;
  localparam int NBLK      = SMALL_CNT + BIG_CNT;
  localparam int BLK_W     = $clog2(NBLK);

  typedef enum logic [1:0] {
    OP_PROG  = 2'b00,
    OP_ERASE = 2'b01,
    OP_LOCK  = 2'b10,
    OP_RSVD  = 2'b11
  } op_e;
endpackage

// File: rtl/flash_blk_decode.sv
module flash_blk_decode #(
  parameter int ADDR_W    = flash_prot_pkg::ADDR_W,
  parameter int SMALL_CNT = flash_prot_pkg::SMALL_CNT,
  parameter int SMALL_LOG = flash_prot_pkg::SMALL_LOG,
  parameter int BIG_LOG   = flash_prot_pkg::BIG_LOG,
  parameter int BLK_W     = flash_prot_pkg::BLK_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BLK_W-1:0]  blk_idx,
  output logic              bank
);
  localparam logic [ADDR_W-1:0] SMALL_END = ADDR_W'(SMALL_CNT << SMALL_LOG);

  // small blocks sit at the bottom; main blocks follow, numbered on
  function automatic logic [BLK_W-1:0] block_of(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] q;
    if (a < SMALL_END) q = a >> SMALL_LOG;
    else               q = ((a - SMALL_END) >> BIG_LOG) + ADDR_W'(SMALL_CNT);
    return q[BLK_W-1:0];
  endfunction

  function automatic logic bank_of(input logic [BLK_W-1:0] idx);
    return idx >= BLK_W'(SMALL_CNT);
  endfunction

  always_comb begin
    blk_idx = block_of(addr);
    bank    = bank_of(blk_idx);
  end
endmodule

// File: rtl/flash_lock_array.sv
module flash_lock_array #(
  parameter int NBLK  = flash_prot_pkg::NBLK,
  parameter int BLK_W = flash_prot_pkg::BLK_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             unlock_en,
  input  logic             lock_en,
  input  logic [BLK_W-1:0] sel,
  output logic [NBLK-1:0]  lock_vec
);
  for (genvar i = 0; i < NBLK; i++) begin : g_bit
    logic hit;
    assign hit = (sel == BLK_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                lock_vec[i] <= 1'b1;
      else if (unlock_en && hit) lock_vec[i] <= 1'b1;
      else if (lock_en && hit)   lock_vec[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_gate_policy.sv
module flash_gate_policy
  import flash_prot_pkg::*;
(
  input  logic       valid,
  input  logic [1:0] op,
  input  logic       lock_bit,
  input  logic       guard_n,
  input  logic       supply_low,
  output logic       grant,
  output logic       fail,
  output logic       erase_ok,
  output logic       lock_ok
);
  function automatic logic permit(input logic [1:0] o, input logic lb,
                                  input logic g, input logic lo);
    if (lo) return 1'b0;
    case (o)
      OP_PROG, OP_ERASE: return g | lb;
      OP_LOCK:           return 1'b1;
      default:           return 1'b0;
    endcase
  endfunction

  always_comb begin
    grant    = valid & permit(op, lock_bit, guard_n, supply_low);
    fail     = valid & ~grant;
    erase_ok = grant & (op == OP_ERASE);
    lock_ok  = grant & (op == OP_LOCK);
  end
endmodule

// File: rtl/flash_protect_check.sv
module flash_protect_check
  import flash_prot_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int NB = NBLK,
  parameter int BW = BLK_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic          write_guard_n,
  input  logic          supply_low,
  output logic          rsp_valid,
  output logic          rsp_grant,
  output logic          rsp_fail,
  output logic [BW-1:0] rsp_block,
  output logic          rsp_bank
);
  logic [BW-1:0] blk_idx;
  logic          blk_bank;
  logic [NB-1:0] lock_vec;
  logic          lock_bit;
  logic          grant_w, fail_w, erase_ok, lock_ok;

  flash_blk_decode #(.ADDR_W(AW), .BLK_W(BW)) u_dec (
    .addr(req_addr), .blk_idx(blk_idx), .bank(blk_bank)
  );

  assign lock_bit = lock_vec[blk_idx];

  flash_gate_policy u_pol (
    .valid(req_valid), .op(req_op), .lock_bit(lock_bit),
    .guard_n(write_guard_n), .supply_low(supply_low),
    .grant(grant_w), .fail(fail_w), .erase_ok(erase_ok), .lock_ok(lock_ok)
  );

  flash_lock_array #(.NBLK(NB), .BLK_W(BW)) u_locks (
    .clk(clk), .rst_n(rst_n), .unlock_en(erase_ok), .lock_en(lock_ok),
    .sel(blk_idx), .lock_vec(lock_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_grant <= 1'b0;
      rsp_fail  <= 1'b0;
      rsp_block <= '0;
      rsp_bank  <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_grant <= grant_w;
      rsp_fail  <= fail_w;
      if (req_valid) begin
        rsp_block <= blk_idx;
        rsp_bank  <= blk_bank;
      end
    end
  end
endmodule

// File: rtl/flash_protect_check_sva.sv
module flash_protect_check_sva
  import flash_prot_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_op,
  input logic [ADDR_W-1:0] req_addr,
  input logic              write_guard_n,
  input logic              supply_low,
  input logic              rsp_valid,
  input logic              rsp_grant,
  input logic              rsp_fail,
  input logic [BLK_W-1:0]  rsp_block,
  input logic              rsp_bank,
  input logic [BLK_W-1:0]  blk_idx,
  input logic [NBLK-1:0]   lock_vec,
  input logic              fail_w,
  input logic              erase_ok,
  input logic              lock_ok
);
  localparam logic [ADDR_W-1:0] SMALL_END = ADDR_W'(SMALL_CNT << SMALL_LOG);

  assert_small_map_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_addr < SMALL_END |=> rsp_block < BLK_W'(SMALL_CNT) && !rsp_bank);
  assert_main_map_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_addr >= SMALL_END |=> rsp_block >= BLK_W'(SMALL_CNT) && rsp_bank);
  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_locked_deny_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !supply_low && !write_guard_n && !req_op[1] && !lock_vec[blk_idx]
    |=> rsp_fail && !rsp_grant);
  assert_guard_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !supply_low && write_guard_n && !req_op[1] |=> rsp_grant);
  assert_erase_unlocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    erase_ok |=> lock_vec[$past(blk_idx)]);
  assert_lowsupply_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && supply_low |=> rsp_fail && !rsp_grant);
  assert_deny_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fail_w |=> $stable(lock_vec));
  assert_lock_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lock_ok |=> !lock_vec[$past(blk_idx)]);
  assert_flag_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_grant && rsp_fail));
endmodule

bind flash_protect_check flash_protect_check_sva u_sva (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .req_addr(req_addr), .write_guard_n(write_guard_n), .supply_low(supply_low),
  .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_fail(rsp_fail),
  .rsp_block(rsp_block), .rsp_bank(rsp_bank), .blk_idx(blk_idx),
  .lock_vec(lock_vec), .fail_w(fail_w), .erase_ok(erase_ok), .lock_ok(lock_ok)
);

// File: tb/flash_protect_check_bench.sv
module flash_protect_check_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic [1:0]  req_op = 0;
  logic [19:0] req_addr = 0;
  logic        write_guard_n = 0;
  logic        supply_low = 0;
  logic        rsp_valid, rsp_grant, rsp_fail, rsp_bank;
  logic [5:0]  rsp_block;

  flash_protect_check u_flash_protect_check (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .write_guard_n(write_guard_n), .supply_low(supply_low),
    .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_fail(rsp_fail),
    .rsp_block(rsp_block), .rsp_bank(rsp_bank)
  );

  always #2 clk = ~clk;

  typedef struct {
    logic       grant;
    logic [5:0] blk;
    logic       bank;
    string      tag;
  } exp_t;

  exp_t sbq[$];
  bit   m_lock[36];
  int   n_chk = 0, n_bad = 0;
  bit   done = 0;

  localparam logic [1:0] PROG = 2'b00, ERASE = 2'b01, LOCK = 2'b10, RSVD = 2'b11;

  function automatic int blk_ref(input logic [19:0] a);
    if (int'(a) < 131072) return int'(a) / 16384;
    return 8 + (int'(a) - 131072) / 32768;
  endfunction

  function automatic logic [19:0] base_of(input int b);
    if (b < 8) return 20'(b * 16384);
    return 20'(131072 + (b - 8) * 32768);
  endfunction

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [19:0] a, input logic g,
                      input logic lo, input string tag);
    int b;
    bit ok;
    exp_t e;
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; write_guard_n = g; supply_low = lo;
    b = blk_ref(a);
    if (lo)               ok = 0;
    else if (op == LOCK)  ok = 1;
    else if (op == RSVD)  ok = 0;
    else                  ok = g || m_lock[b];
    if (ok && op == ERASE) m_lock[b] = 1;
    if (ok && op == LOCK)  m_lock[b] = 0;
    e.grant = ok; e.blk = 6'(b); e.bank = (b >= 8); e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 0;
  endtask

  // monitor: results are due 1 ns after the rising edge that follows a request
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n) begin
        if (rsp_valid) begin
          if (sbq.size() == 0) begin
            check(0, "R3 unexpected result", "valid", "idle");
          end else begin
            exp_t e;
            e = sbq.pop_front();
            check(rsp_grant == e.grant && rsp_fail == !e.grant &&
                  rsp_block == e.blk && rsp_bank == e.bank, e.tag,
                  $sformatf("g%0d f%0d blk%0d bank%0d", rsp_grant, rsp_fail, rsp_block, rsp_bank),
                  $sformatf("g%0d f%0d blk%0d bank%0d", e.grant, !e.grant, e.blk, e.bank));
          end
        end else if (sbq.size() != 0) begin
          check(0, {"R3 late result ", sbq[0].tag}, "idle", "valid");
          void'(sbq.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(0, "watchdog", "hung", "finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 36; i++) m_lock[i] = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check(rsp_valid == 0 && rsp_grant == 0, "R9 reset outputs",
          $sformatf("v%0d g%0d", rsp_valid, rsp_grant), "v0 g0");

    // R9 all unlocked after reset; R1 and R2 decode across every block
    for (int b = 0; b < 36; b++)
      send(PROG, base_of(b) + 20'((b * 97) & 16'h3FFF), 0, 0, b < 8 ? "R1 R9" : "R2 R9");
    send(PROG, 20'h03FFF, 0, 0, "R1 boundary");
    send(PROG, 20'h04000, 0, 0, "R1 boundary");
    send(PROG, 20'h1FFFF, 0, 0, "R1 top");
    send(PROG, 20'h20000, 0, 0, "R2 first main");
    send(PROG, 20'h27FFF, 0, 0, "R2 boundary");
    send(PROG, 20'h28000, 0, 0, "R2 boundary");
    send(PROG, 20'hFFFFF, 0, 0, "R2 last");
    idle();
    @(posedge clk); #2;
    check(rsp_valid == 0, "R3 idle", $sformatf("%0d", rsp_valid), "0");

    // R10 lock, R4 refusal
    send(LOCK, 20'h00000, 0, 0, "R10 lock");
    send(LOCK, 20'h1C000, 1, 0, "R10 lock guard high");
    send(LOCK, 20'h20000, 0, 0, "R10 lock");
    send(LOCK, 20'hF8000, 0, 0, "R10 lock");
    send(PROG, 20'h00123, 0, 0, "R4 prog locked");
    send(PROG, 20'h1C000, 0, 0, "R4 prog locked");
    send(PROG, 20'h20001, 0, 0, "R4 prog locked");
    send(ERASE, 20'hFFFF0, 0, 0, "R4 erase locked");
    send(PROG, 20'h04000, 0, 0, "R4 unlocked neighbour");
    send(ERASE, 20'h1C123, 0, 0, "R8 denied erase");
    send(PROG, 20'h1C000, 0, 0, "R8 still locked");

    // R3 back-to-back: lock then program same block next cycle
    send(LOCK, 20'h30000, 0, 0, "R3 lock");
    send(PROG, 20'h30001, 0, 0, "R3 next-cycle sees lock");

    // R5 guard high overrides, program keeps lock
    send(PROG, 20'h00010, 1, 0, "R5 guard override prog");
    send(PROG, 20'h00010, 0, 0, "R5 prog kept lock");

    // R6 erase unlocks
    send(ERASE, 20'h20000, 1, 0, "R6 erase guard high");
    send(PROG, 20'h20000, 0, 0, "R6 unlocked after erase");
    send(ERASE, 20'h30000, 1, 0, "R6 erase");
    send(PROG, 20'h37FFF, 0, 0, "R6 unlocked after erase");

    // R7 supply lockout, R8 nothing changes
    send(PROG, 20'h08000, 0, 1, "R7 prog low supply");
    send(ERASE, 20'hF8000, 1, 1, "R7 erase low supply");
    send(LOCK, 20'h0C000, 0, 1, "R7 lock low supply");
    send(PROG, 20'h0C000, 0, 0, "R8 lock unchanged");
    send(PROG, 20'hF8000, 0, 0, "R8 still locked");

    send(RSVD, 20'h40000, 1, 0, "R10 reserved op");
    send(PROG, 20'h40000, 0, 0, "R10 reserved no effect");
    idle();

    while (sbq.size() != 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule